// File: doc/BRIEF.md
# Stack and Interrupt Sequencer

This block carries out the stack-based control transfers of an 8-bit processor. It owns the stack pointer and talks to memory through one byte-wide port: a 16-bit address, write data, a write strobe and read data. Read data returns one cycle after the address. The surrounding core raises `start` for one cycle with an operation code. That code selects a register push, a register pull, a break, a return from interrupt or a return from subroutine. The block then runs the memory cycles for that operation on its own.

The program counter, status byte and A/X/Y values are sampled on the start cycle. The block never holds the architectural registers. It returns new values through write strobes, and these are valid only in the single cycle where `done` is high. A mode input chooses the low-power-process behaviour for break, which also clears the decimal flag.

The controller uses these states: IDLE, BRK_PCH, BRK_PCL, BRK_PSR, BRK_VLO, BRK_VHI, RTI_PSR, RTI_PCL, RTI_PCH, RTS_PCL, RTS_PCH, PUSH_ONE, PULL_ONE and FINISH. Its transitions are:
- IDLE goes to the first state of the requested operation when `start` is high with a supported code. Otherwise it stays in IDLE.
- Break runs BRK_PCH → BRK_PCL → BRK_PSR → BRK_VLO → BRK_VHI → FINISH.
- Return from interrupt runs RTI_PSR → RTI_PCL → RTI_PCH → FINISH.
- Return from subroutine runs RTS_PCL → RTS_PCH → FINISH.
- Every push runs PUSH_ONE → FINISH, and every pull runs PULL_ONE → FINISH.
- FINISH always returns to IDLE.

Top module: `stack_seq`

## Requirements
- R1: After reset, `sp` is 0xFF. `done`, `mem_we` and all result strobes are low.
- R2: A push drives address {0x01, sp} with the write strobe high in the cycle after start, then decrements `sp`. Codes 3, 4 and 5 push the A, X and Y values sampled at start.
- R3: A pull increments `sp` and presents address {0x01, new sp} in the cycle after start. The byte returned by memory is delivered in the next cycle.
  - Codes 7, 8 and 9 write that byte to A, X or Y. `reg_wr_sel` bit 0 selects A, bit 1 selects X and bit 2 selects Y.
  - The same codes write status with Z (bit 1) set when the byte is zero and N (bit 7) equal to byte bit 7. All other status bits are unchanged.
  - Code 10 writes the pulled byte unchanged to status.
- R4: Every status push (code 6 and break) writes the sampled status OR 0x30.
- R5: Break (code 0) writes the high byte of PC−1, then the low byte of PC−1, then the status. It then reads 0xFFFE and 0xFFFF. It loads PC with {byte at 0xFFFF, byte at 0xFFFE} and writes status with the interrupt-disable bit (bit 2) set.
- R6: With `cmos_mode` high, break also clears the decimal bit (bit 3) of the written status. With `cmos_mode` low, bit 3 is kept.
- R7: Return from interrupt (code 1) pulls status, then PC low, then PC high. It loads both PC and status from the pulled bytes.
- R8: Return from subroutine (code 2) pulls PC low, then PC high. It loads PC with that address plus one, wrapping 0xFFFF to 0x0000.
- R9: `sp` wraps from 0x00 to 0xFF on a push and from 0xFF to 0x00 on a pull.
- R10: Sequence completion and ignored starts:
  - `done` is high for exactly one cycle, the cycle after the last memory access. In that cycle there is no write, and the sequencer accepts a new start in the following cycle.
  - A start while a sequence runs has no effect.
  - A start with codes 11 to 15 produces no memory access, no `done` and no change of `sp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to begin an operation |
| op | input | 4 | Operation code (0 break, 1 return from interrupt, 2 return from subroutine, 3–5 push A/X/Y, 6 push status, 7–9 pull A/X/Y, 10 pull status) |
| cmos_mode | input | 1 | Break also clears the decimal flag |
| pc_in | input | 16 | Current program counter, sampled at start |
| p_in | input | 8 | Current status, sampled at start |
| a_in | input | 8 | Accumulator value, sampled at start |
| x_in | input | 8 | X value, sampled at start |
| y_in | input | 8 | Y value, sampled at start |
| mem_addr | output | 16 | Memory address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write strobe |
| mem_rdata | input | 8 | Memory read data, one cycle after address |
| sp | output | 8 | Stack pointer |
| done | output | 1 | One-cycle end-of-sequence pulse |
| pc_wr_en | output | 1 | Load program counter |
| pc_wr_data | output | 16 | New program counter |
| p_wr_en | output | 1 | Load status |
| p_wr_data | output | 8 | New status |
| reg_wr_sel | output | 3 | One-hot load of A (bit 0), X (bit 1), Y (bit 2) |
| reg_wr_data | output | 8 | Value for the selected register |

## Verification
A stack pointer that is off by one shows at once on `sp` and on the address of the next stack access, so every push and pull cycle is compared against an independent pointer model. A state machine that skips or repeats a state shows as a misplaced address or write strobe in that same cycle, or as `done` arriving early or late. A mis-captured byte stays invisible until the FINISH cycle, where the PC, status or register strobe carries the wrong value. Break and return sequences are therefore also checked end to end: values pushed by one operation are pulled back by a later one.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [3:0] {
        OP_BRK   = 4'd0,
        OP_RTI   = 4'd1,
        OP_RTS   = 4'd2,
        OP_PSH_A = 4'd3,
        OP_PSH_X = 4'd4,
        OP_PSH_Y = 4'd5,
        OP_PSH_P = 4'd6,
        OP_PUL_A = 4'd7,
        OP_PUL_X = 4'd8,
        OP_PUL_Y = 4'd9,
        OP_PUL_P = 4'd10
    } seq_op_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BRK_PCH,
        ST_BRK_PCL,
        ST_BRK_PSR,
        ST_BRK_VLO,
        ST_BRK_VHI,
        ST_RTI_PSR,
        ST_RTI_PCL,
        ST_RTI_PCH,
        ST_RTS_PCL,
        ST_RTS_PCH,
        ST_PUSH_ONE,
        ST_PULL_ONE,
        ST_FINISH
    } seq_state_e;

    localparam int FLAG_Z = 1;
    localparam int FLAG_I = 2;
    localparam int FLAG_D = 3;
    localparam int FLAG_N = 7;
    localparam logic [7:0] PUSH_FORCE = 8'h30;
    localparam int NUM_GPR = 3;

    function automatic seq_op_e pull_op_of(input int idx);
        case (idx)
            0:       return OP_PUL_A;
            1:       return OP_PUL_X;
            default: return OP_PUL_Y;
        endcase
    endfunction

endpackage

// File: rtl/stack_seq_sp.sv
module stack_seq_sp #(
    parameter int         DW      = 8,
    parameter logic [7:0] SP_INIT = 8'hFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          dec,
    input  logic          inc,
    output logic [DW-1:0] sp,
    output logic [DW-1:0] sp_up
);

    localparam logic [DW-1:0] ONE = DW'(1);

    assign sp_up = sp + ONE;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp <= SP_INIT;
        end else if (dec) begin
            sp <= sp - ONE;
        end else if (inc) begin
            sp <= sp_up;
        end
    end

endmodule

// File: rtl/stack_seq_fsm.sv
module stack_seq_fsm
    import stack_seq_pkg::*;
#(
    parameter int          DW     = 8,
    parameter int          AW     = 16,
    parameter logic [7:0]  PAGE   = 8'h01,
    parameter logic [15:0] VECTOR = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic          cmos_mode,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] p_in,
    input  logic [DW-1:0] a_in,
    input  logic [DW-1:0] x_in,
    input  logic [DW-1:0] y_in,
    input  logic [DW-1:0] mem_rdata,
    input  logic [DW-1:0] sp,
    input  logic [DW-1:0] sp_up,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          sp_dec,
    output logic          sp_inc,
    output logic          fin,
    output seq_op_e       op_q,
    output logic          cmos_q,
    output logic [DW-1:0] p_q,
    output logic [DW-1:0] lo_q,
    output logic [DW-1:0] pulled_p_q
);

    localparam logic [AW-1:0] VEC_LO = VECTOR;
    localparam logic [AW-1:0] VEC_HI = VECTOR + AW'(1);

    seq_state_e    state, state_nx;
    logic [AW-1:0] pc_m1_q;
    logic [DW-1:0] a_q, x_q, y_q;
    logic [AW-1:0] push_addr, pull_addr;

    assign push_addr = {PAGE, sp};
    assign pull_addr = {PAGE, sp_up};
    assign fin       = (state == ST_FINISH);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    case (seq_op_e'(op))
                        OP_BRK:   state_nx = ST_BRK_PCH;
                        OP_RTI:   state_nx = ST_RTI_PSR;
                        OP_RTS:   state_nx = ST_RTS_PCL;
                        OP_PSH_A, OP_PSH_X, OP_PSH_Y, OP_PSH_P:
                                  state_nx = ST_PUSH_ONE;
                        OP_PUL_A, OP_PUL_X, OP_PUL_Y, OP_PUL_P:
                                  state_nx = ST_PULL_ONE;
                        default:  state_nx = ST_IDLE;
                    endcase
                end
            end
            ST_BRK_PCH:  state_nx = ST_BRK_PCL;
            ST_BRK_PCL:  state_nx = ST_BRK_PSR;
            ST_BRK_PSR:  state_nx = ST_BRK_VLO;
            ST_BRK_VLO:  state_nx = ST_BRK_VHI;
            ST_BRK_VHI:  state_nx = ST_FINISH;
            ST_RTI_PSR:  state_nx = ST_RTI_PCL;
            ST_RTI_PCL:  state_nx = ST_RTI_PCH;
            ST_RTI_PCH:  state_nx = ST_FINISH;
            ST_RTS_PCL:  state_nx = ST_RTS_PCH;
            ST_RTS_PCH:  state_nx = ST_FINISH;
            ST_PUSH_ONE: state_nx = ST_FINISH;
            ST_PULL_ONE: state_nx = ST_FINISH;
            ST_FINISH:   state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // memory-side outputs
    always_comb begin
        mem_addr  = '0;
        mem_wdata = '0;
        mem_we    = 1'b0;
        sp_dec    = 1'b0;
        sp_inc    = 1'b0;
        unique case (state)
            ST_BRK_PCH: begin
                mem_addr = push_addr; mem_we = 1'b1; sp_dec = 1'b1;
                mem_wdata = pc_m1_q[AW-1:DW];
            end
            ST_BRK_PCL: begin
                mem_addr = push_addr; mem_we = 1'b1; sp_dec = 1'b1;
                mem_wdata = pc_m1_q[DW-1:0];
            end
            ST_BRK_PSR: begin
                mem_addr = push_addr; mem_we = 1'b1; sp_dec = 1'b1;
                mem_wdata = p_q | PUSH_FORCE;
            end
            ST_PUSH_ONE: begin
                mem_addr = push_addr; mem_we = 1'b1; sp_dec = 1'b1;
                case (op_q)
                    OP_PSH_A: mem_wdata = a_q;
                    OP_PSH_X: mem_wdata = x_q;
                    OP_PSH_Y: mem_wdata = y_q;
                    default:  mem_wdata = p_q | PUSH_FORCE;
                endcase
            end
            ST_BRK_VLO: mem_addr = VEC_LO;
            ST_BRK_VHI: mem_addr = VEC_HI;
            ST_RTI_PSR, ST_RTI_PCL, ST_RTI_PCH,
            ST_RTS_PCL, ST_RTS_PCH, ST_PULL_ONE: begin
                mem_addr = pull_addr;
                sp_inc   = 1'b1;
            end
            default: ;
        endcase
    end

    // operand sampling and read-data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q       <= OP_BRK;
            cmos_q     <= 1'b0;
            pc_m1_q    <= '0;
            p_q        <= '0;
            a_q        <= '0;
            x_q        <= '0;
            y_q        <= '0;
            lo_q       <= '0;
            pulled_p_q <= '0;
        end else begin
            if (state == ST_IDLE && start) begin
                op_q    <= seq_op_e'(op);
                cmos_q  <= cmos_mode;
                pc_m1_q <= pc_in - AW'(1);
                p_q     <= p_in;
                a_q     <= a_in;
                x_q     <= x_in;
                y_q     <= y_in;
            end
            if (state == ST_RTI_PCL) pulled_p_q <= mem_rdata;
            if (state == ST_BRK_VHI || state == ST_RTI_PCH || state == ST_RTS_PCH)
                lo_q <= mem_rdata;
        end
    end

endmodule

// File: rtl/stack_seq_result.sv
module stack_seq_result
    import stack_seq_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input  logic                fin,
    input  seq_op_e             op_q,
    input  logic                cmos_q,
    input  logic [DW-1:0]       p_q,
    input  logic [DW-1:0]       lo_q,
    input  logic [DW-1:0]       pulled_p_q,
    input  logic [DW-1:0]       mem_rdata,
    output logic                pc_wr_en,
    output logic [AW-1:0]       pc_wr_data,
    output logic                p_wr_en,
    output logic [DW-1:0]       p_wr_data,
    output logic [NUM_GPR-1:0]  reg_wr_sel,
    output logic [DW-1:0]       reg_wr_data
);

    logic [AW-1:0] joined;
    logic [DW-1:0] p_nz;

    assign joined      = {mem_rdata, lo_q};
    assign reg_wr_data = mem_rdata;

    always_comb begin
        p_nz         = p_q;
        p_nz[FLAG_Z] = (mem_rdata == '0);
        p_nz[FLAG_N] = mem_rdata[DW-1];
    end

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_gpr
        assign reg_wr_sel[g] = fin && (op_q == pull_op_of(g));
    end

    always_comb begin
        pc_wr_en   = 1'b0;
        pc_wr_data = '0;
        p_wr_en    = 1'b0;
        p_wr_data  = '0;
        if (fin) begin
            case (op_q)
                OP_BRK: begin
                    pc_wr_en  = 1'b1;
                    pc_wr_data = joined;
                    p_wr_en   = 1'b1;
                    p_wr_data = p_q;
                    p_wr_data[FLAG_I] = 1'b1;
                    if (cmos_q) p_wr_data[FLAG_D] = 1'b0;
                end
                OP_RTI: begin
                    pc_wr_en   = 1'b1;
                    pc_wr_data = joined;
                    p_wr_en    = 1'b1;
                    p_wr_data  = pulled_p_q;
                end
                OP_RTS: begin
                    pc_wr_en   = 1'b1;
                    pc_wr_data = joined + AW'(1);
                end
                OP_PUL_A, OP_PUL_X, OP_PUL_Y: begin
                    p_wr_en   = 1'b1;
                    p_wr_data = p_nz;
                end
                OP_PUL_P: begin
                    p_wr_en   = 1'b1;
                    p_wr_data = mem_rdata;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter int          DW      = 8,
    parameter int          AW      = 16,
    parameter logic [7:0]  SP_INIT = 8'hFF,
    parameter logic [7:0]  PAGE    = 8'h01,
    parameter logic [15:0] VECTOR  = 16'hFFFE
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [3:0]    op,
    input  logic          cmos_mode,
    input  logic [15:0]   pc_in,
    input  logic [7:0]    p_in,
    input  logic [7:0]    a_in,
    input  logic [7:0]    x_in,
    input  logic [7:0]    y_in,
    output logic [15:0]   mem_addr,
    output logic [7:0]    mem_wdata,
    output logic          mem_we,
    input  logic [7:0]    mem_rdata,
    output logic [7:0]    sp,
    output logic          done,
    output logic          pc_wr_en,
    output logic [15:0]   pc_wr_data,
    output logic          p_wr_en,
    output logic [7:0]    p_wr_data,
    output logic [2:0]    reg_wr_sel,
    output logic [7:0]    reg_wr_data
);

    logic          sp_dec, sp_inc, fin, cmos_q;
    logic [DW-1:0] sp_up, p_q, lo_q, pulled_p_q;
    seq_op_e       op_q;

    stack_seq_sp #(.DW(DW), .SP_INIT(SP_INIT)) u_sp (
        .clk(clk), .rst_n(rst_n), .dec(sp_dec), .inc(sp_inc),
        .sp(sp), .sp_up(sp_up)
    );

    stack_seq_fsm #(.DW(DW), .AW(AW), .PAGE(PAGE), .VECTOR(VECTOR)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cmos_mode(cmos_mode),
        .pc_in(pc_in), .p_in(p_in), .a_in(a_in), .x_in(x_in), .y_in(y_in),
        .mem_rdata(mem_rdata), .sp(sp), .sp_up(sp_up),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .sp_dec(sp_dec), .sp_inc(sp_inc), .fin(fin), .op_q(op_q),
        .cmos_q(cmos_q), .p_q(p_q), .lo_q(lo_q), .pulled_p_q(pulled_p_q)
    );

    stack_seq_result #(.DW(DW), .AW(AW)) u_res (
        .fin(fin), .op_q(op_q), .cmos_q(cmos_q), .p_q(p_q), .lo_q(lo_q),
        .pulled_p_q(pulled_p_q), .mem_rdata(mem_rdata),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
        .p_wr_en(p_wr_en), .p_wr_data(p_wr_data),
        .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data)
    );

    assign done = fin;

endmodule

// File: rtl/stack_seq_checker.sv
module stack_seq_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] mem_addr,
    input logic        mem_we,
    input logic [7:0]  sp,
    input logic        done,
    input logic        pc_wr_en,
    input logic        p_wr_en,
    input logic        p_i_bit,
    input logic [2:0]  reg_wr_sel
);

    p_push_page_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[15:8] == 8'h01));

    p_push_dec_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) - 8'd1));

    p_pull_inc_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr[15:8] == 8'h01 && !mem_we) |=> (sp == $past(mem_addr[7:0])));

    p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(reg_wr_sel));

    p_vec_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_addr == 16'hFFFE) |=> (mem_addr == 16'hFFFF));

    p_brk_iflag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mem_addr) == 16'hFFFF) |-> (p_wr_en && p_i_bit));

    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_we);

    p_strobe_in_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_wr_en || p_wr_en || (reg_wr_sel != 3'b000)) |-> done);

endmodule

bind stack_seq stack_seq_checker u_stack_seq_checker (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_we(mem_we),
    .sp(sp), .done(done), .pc_wr_en(pc_wr_en), .p_wr_en(p_wr_en),
    .p_i_bit(p_wr_data[2]), .reg_wr_sel(reg_wr_sel)
);

// File: tb/stack_seq_bench.sv
module stack_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  op = 4'd0;
    logic        cmos_mode = 1'b0;
    logic [15:0] pc_in = '0;
    logic [7:0]  p_in = '0, a_in = '0, x_in = '0, y_in = '0;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic        mem_we;
    logic [7:0]  mem_rdata = '0;
    logic [7:0]  sp;
    logic        done, pc_wr_en, p_wr_en;
    logic [15:0] pc_wr_data;
    logic [7:0]  p_wr_data, reg_wr_data;
    logic [2:0]  reg_wr_sel;

    int checks = 0;
    int fails  = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    stack_seq u_stack_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cmos_mode(cmos_mode),
        .pc_in(pc_in), .p_in(p_in), .a_in(a_in), .x_in(x_in), .y_in(y_in),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we),
        .mem_rdata(mem_rdata), .sp(sp), .done(done),
        .pc_wr_en(pc_wr_en), .pc_wr_data(pc_wr_data),
        .p_wr_en(p_wr_en), .p_wr_data(p_wr_data),
        .reg_wr_sel(reg_wr_sel), .reg_wr_data(reg_wr_data)
    );

    // memory seen by the design
    logic [7:0] ram [int];
    // memory as the reference model expects it
    logic [7:0] ref_mem [int];

    function automatic logic [7:0] ram_rd(input int a);
        return ram.exists(a) ? ram[a] : 8'h00;
    endfunction
    function automatic logic [7:0] ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 8'h00;
    endfunction

    always @(posedge clk) begin
        if (mem_we) ram[int'(mem_addr)] = mem_wdata;
        mem_rdata <= ram_rd(int'(mem_addr));
    end

    // reference model state
    int          model_sp = 255;
    logic [15:0] q_addr[$];
    logic        q_we[$];
    logic [7:0]  q_wd[$];

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    task automatic m_push(input logic [7:0] b);
        int a = 256 + model_sp;
        q_addr.push_back(16'(a)); q_we.push_back(1'b1); q_wd.push_back(b);
        ref_mem[a] = b;
        model_sp = (model_sp + 255) % 256;
    endtask

    task automatic m_pull(output logic [7:0] b);
        int a;
        model_sp = (model_sp + 1) % 256;
        a = 256 + model_sp;
        q_addr.push_back(16'(a)); q_we.push_back(1'b0); q_wd.push_back(8'h00);
        b = ref_rd(a);
    endtask

    task automatic m_read(input logic [15:0] a, output logic [7:0] b);
        q_addr.push_back(a); q_we.push_back(1'b0); q_wd.push_back(8'h00);
        b = ref_rd(int'(a));
    endtask

    task automatic run_op(input logic [3:0] o, input logic cm, input logic [15:0] pc,
                          input logic [7:0] p, input logic [7:0] a, input logic [7:0] x,
                          input logic [7:0] y, input string tag, input bit poke);
        logic        e_pc_we = 0, e_p_we = 0;
        logic [15:0] e_pc = '0, pm1;
        logic [7:0]  e_p = '0, e_rd = '0, b0, b1, b2;
        logic [2:0]  e_sel = '0;
        int n;
        q_addr.delete(); q_we.delete(); q_wd.delete();
        case (o)
            4'd0: begin
                pm1 = pc - 16'd1;
                m_push(pm1[15:8]); m_push(pm1[7:0]); m_push(p | 8'h30);
                m_read(16'hFFFE, b0); m_read(16'hFFFF, b1);
                e_pc_we = 1; e_pc = {b1, b0};
                e_p_we = 1; e_p = p | 8'h04;
                if (cm) e_p = e_p & 8'hF7;
            end
            4'd1: begin
                m_pull(b0); m_pull(b1); m_pull(b2);
                e_pc_we = 1; e_pc = {b2, b1}; e_p_we = 1; e_p = b0;
            end
            4'd2: begin
                m_pull(b0); m_pull(b1);
                e_pc_we = 1; e_pc = {b1, b0} + 16'd1;
            end
            4'd3: m_push(a);
            4'd4: m_push(x);
            4'd5: m_push(y);
            4'd6: m_push(p | 8'h30);
            4'd7, 4'd8, 4'd9: begin
                m_pull(b0);
                e_sel = 3'b001 << (o - 4'd7);
                e_rd = b0;
                e_p_we = 1;
                e_p = (p & 8'h7D) | (b0 & 8'h80) | ((b0 == 8'h00) ? 8'h02 : 8'h00);
            end
            default: begin
                m_pull(b0);
                e_p_we = 1; e_p = b0;
            end
        endcase
        @(negedge clk);
        start = 1; op = o; cmos_mode = cm; pc_in = pc; p_in = p;
        a_in = a; x_in = x; y_in = y;
        @(negedge clk);
        start = 0;
        // scramble sampled inputs: the sequence must use the start-cycle values
        pc_in = ~pc; p_in = ~p; a_in = ~a; x_in = ~x; y_in = ~y;
        n = q_addr.size();
        for (int i = 0; i < n; i++) begin
            chk(mem_addr == q_addr[i], tag, "address", mem_addr, q_addr[i]);
            chk(mem_we == q_we[i], tag, "write strobe", mem_we, q_we[i]);
            if (q_we[i]) chk(mem_wdata == q_wd[i], tag, "write data", mem_wdata, q_wd[i]);
            chk(done == 1'b0, "R10", "early done", done, 0);
            if (poke && i == 0) begin start = 1; op = 4'd3; end
            else start = 0;
            @(negedge clk);
        end
        start = 0;
        chk(done == 1'b1, "R10", "done at end", done, 1);
        chk(mem_we == 1'b0, "R10", "write at done", mem_we, 0);
        chk(pc_wr_en == e_pc_we, tag, "pc strobe", pc_wr_en, e_pc_we);
        if (e_pc_we) chk(pc_wr_data == e_pc, tag, "pc value", pc_wr_data, e_pc);
        chk(p_wr_en == e_p_we, tag, "status strobe", p_wr_en, e_p_we);
        if (e_p_we) chk(p_wr_data == e_p, tag, "status value", p_wr_data, e_p);
        chk(reg_wr_sel == e_sel, tag, "register select", reg_wr_sel, e_sel);
        if (e_sel != 0) chk(reg_wr_data == e_rd, tag, "register value", reg_wr_data, e_rd);
        @(negedge clk);
        chk(done == 1'b0, "R10", "done width", done, 0);
        chk(int'(sp) == model_sp, tag, "stack pointer", sp, model_sp);
    endtask

    initial begin
        ram[32'hFFFE] = 8'h00; ref_mem[32'hFFFE] = 8'h00;
        ram[32'hFFFF] = 8'h80; ref_mem[32'hFFFF] = 8'h80;
        ram[32'h0100] = 8'h80; ref_mem[32'h0100] = 8'h80;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1;
        // R1 reset state
        chk(sp == 8'hFF, "R1", "reset sp", sp, 8'hFF);
        chk(done == 1'b0, "R1", "reset done", done, 0);
        chk(mem_we == 1'b0, "R1", "reset write", mem_we, 0);
        chk(pc_wr_en == 1'b0 && p_wr_en == 1'b0 && reg_wr_sel == 3'b000,
            "R1", "reset strobes", {pc_wr_en, p_wr_en, reg_wr_sel}, 0);
        // R2 pushes of A, X, Y; R4 status pushes
        run_op(4'd3, 0, 16'h0, 8'h00, 8'h5A, 8'h00, 8'h00, "R2", 0);
        run_op(4'd4, 0, 16'h0, 8'h00, 8'h00, 8'hA5, 8'h00, "R2", 0);
        run_op(4'd5, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R2", 0);
        run_op(4'd6, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R4", 0);
        run_op(4'd6, 0, 16'h0, 8'hC3, 8'h00, 8'h00, 8'h00, "R4", 0);
        // R3 pulls into A, X, Y and status
        run_op(4'd7, 0, 16'h0, 8'h02, 8'h00, 8'h00, 8'h00, "R3", 0);
        run_op(4'd8, 0, 16'h0, 8'hFF, 8'h00, 8'h00, 8'h00, "R3", 0);
        run_op(4'd9, 0, 16'h0, 8'h41, 8'h00, 8'h00, 8'h00, "R3", 0);
        run_op(4'd10, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R3", 0);
        run_op(4'd7, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R3", 0);
        // R9 wrap both ways
        run_op(4'd7, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R9", 0);
        run_op(4'd3, 0, 16'h0, 8'h00, 8'h11, 8'h00, 8'h00, "R9", 0);
        // R5 break with a start poked mid-sequence (R10), decimal kept (R6)
        run_op(4'd0, 0, 16'h1234, 8'h08, 8'h00, 8'h00, 8'h00, "R5", 1);
        // R7 return from interrupt
        run_op(4'd1, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R7", 0);
        // R6 break in CMOS mode clears decimal
        run_op(4'd0, 1, 16'h0100, 8'h09, 8'h00, 8'h00, 8'h00, "R6", 0);
        // R8 return from subroutine, then the wrap case
        run_op(4'd2, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R8", 0);
        run_op(4'd3, 0, 16'h0, 8'h00, 8'hFF, 8'h00, 8'h00, "R8", 0);
        run_op(4'd3, 0, 16'h0, 8'h00, 8'hFF, 8'h00, 8'h00, "R8", 0);
        run_op(4'd2, 0, 16'h0, 8'h00, 8'h00, 8'h00, 8'h00, "R8", 0);
        // R10 unsupported code is ignored
        @(negedge clk);
        start = 1; op = 4'hF;
        @(negedge clk);
        start = 0;
        for (int k = 0; k < 3; k++) begin
            chk(mem_we == 1'b0 && mem_addr == 16'h0000, "R10", "access on bad code",
                {mem_we, mem_addr}, 0);
            chk(done == 1'b0, "R10", "done on bad code", done, 0);
            chk(int'(sp) == model_sp, "R10", "sp on bad code", sp, model_sp);
            @(negedge clk);
        end
        // the sequencer still works afterwards
        run_op(4'd6, 0, 16'h0, 8'h81, 8'h00, 8'h00, 8'h00, "R4", 0);
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule